// File: doc/BRIEF.md
# Periodic Tick Timer

This block divides a reference tick down into periodic or single interrupts. A reference enable pulse arrives at a nominal 32768 Hz rate (after an optional parameterised prescale divider), and a 17-bit down counter, loaded from a 16-bit reload value, decrements once per prescaled tick. When the count reaches zero a sticky flag is raised, and the counter is then reloaded (periodic mode) or stopped (single-shot mode). For a wanted rate f that is a power of two, software loads 0x8000 >> log2(f).

Software reaches the block through a small byte-wide register port. A control byte holds the enable, interrupt enable, flag and mode bits and shows a watchdog-busy status taken from a neighbouring block. Two further bytes hold the halves of the reload value, and a fourth byte exposes the prescale phase, which software can zero. The interrupt output is the flag qualified by the interrupt enable.

Top module: `tick_timer`

## Requirements
- R1: After reset the control byte, both reload bytes and the prescale byte read 0x00 (busy input low), and `irq` is 0.
- R2: Address 0 is control: bit 3 enable, bit 2 interrupt enable, bit 1 flag, bit 0 mode (1 periodic, 0 single-shot), bit 7 reads the `wdog_busy` input, bits 6..4 read 0 and ignore writes. Address 1 holds reload bits 7..0 and address 2 reload bits 15..8; both read back what was written.
- R3: A control write that sets the enable bit while `wdog_busy` is high leaves the enable at 0; clearing the enable is always accepted.
- R4: Address 3 reads the prescale phase, which advances on each `ref_tick` and wraps after DIV ticks; writing 0x00 to it zeroes the phase, any other value is ignored.
- R5: When the enable rises the counter loads the reload value; with the phase at 0, the flag is set by exactly the DIV*reload-th reference tick and not earlier.
- R6: In periodic mode an expiry keeps the enable set and reloads the counter, so the next expiry follows another DIV*reload ticks.
- R7: In single-shot mode an expiry clears the enable bit and the counter stops; further ticks cause nothing.
- R8: The flag stays set until a control write with bit 1 equal to 1; a control write with bit 1 equal to 0 leaves it set.
- R9: `irq` is high exactly when both the flag and the interrupt enable bit are 1.
- R10: A reload value of 0x0000 counts as 65536 prescaled ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | AW | Register address |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| ref_tick | input | 1 | Reference tick enable, one clock wide per tick |
| wdog_busy | input | 1 | Busy status of the neighbouring watchdog |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is the expiry of a zero reload, which needs 65536 prescaled ticks; the bench instantiates the block with a divider of 2 and holds `ref_tick` high for long bursts so that 131072 reference ticks pass in as many clocks, and samples the flag one tick before and exactly at the expiry. Exact expiry timing also depends on the prescale phase, so every timing case first zeroes the phase through its register before enabling the counter. The busy gate is reached by raising `wdog_busy` around a control write.

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int DIV = 4,
  parameter int AW  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          ref_tick,
  input  logic          wdog_busy,
  output logic          irq
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int CW = 17;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_RLO  = AW'(1);
  localparam logic [AW-1:0] A_RHI  = AW'(2);
  localparam logic [AW-1:0] A_PRE  = AW'(3);

  logic          en_q, ien_q, flag_q, mode_q;
  logic [7:0]    rlo_q, rhi_q;
  logic [PW-1:0] pre_q;
  logic [CW-1:0] cnt_q;

  wire wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  wire pre_clr  = reg_wr && (reg_addr == A_PRE) && (reg_wdata == 8'h00);
  wire pre_last = (pre_q == PW'(DIV - 1));
  wire dec      = en_q && ref_tick && pre_last && !pre_clr && (cnt_q != '0);
  wire expire   = dec && (cnt_q == CW'(1));
  wire en_start = wr_ctrl && reg_wdata[3] && !en_q && !wdog_busy;
  wire [CW-1:0] reload_eff = ({rhi_q, rlo_q} == 16'h0000) ? CW'(17'h10000)
                                                          : {1'b0, rhi_q, rlo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (pre_clr) begin
      pre_q <= '0;
    end else if (ref_tick) begin
      pre_q <= pre_last ? '0 : pre_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ien_q  <= 1'b0;
      mode_q <= 1'b0;
      rlo_q  <= '0;
      rhi_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= reg_wdata[3] ? (en_q | !wdog_busy) : 1'b0;
        ien_q  <= reg_wdata[2];
        mode_q <= reg_wdata[0];
      end else if (expire && !mode_q) begin
        en_q <= 1'b0;
      end
      if (reg_wr && reg_addr == A_RLO) rlo_q <= reg_wdata;
      if (reg_wr && reg_addr == A_RHI) rhi_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (expire) begin
      flag_q <= 1'b1;
    end else if (wr_ctrl && reg_wdata[1]) begin
      flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (en_start) begin
      cnt_q <= reload_eff;
    end else if (dec) begin
      cnt_q <= expire ? (mode_q ? reload_eff : '0) : cnt_q - CW'(1);
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {wdog_busy, 3'b000, en_q, ien_q, flag_q, mode_q};
      A_RLO:   reg_rdata = rlo_q;
      A_RHI:   reg_rdata = rhi_q;
      A_PRE:   reg_rdata = 8'(pre_q);
      default: reg_rdata = 8'h00;
    endcase
  end

  assign irq = flag_q & ien_q;

  a_r3_busy_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> !$past(wdog_busy));

  a_r4_pre_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pre_clr |=> (pre_q == '0));

  a_r5_flag_at_one: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(en_q && ref_tick && cnt_q == CW'(1)));

  a_r6_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && mode_q && !wr_ctrl) |=> (en_q && cnt_q == $past(reload_eff)));

  a_r7_single_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !mode_q && !wr_ctrl) |=> (!en_q && cnt_q == '0));

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(wr_ctrl && reg_wdata[1])) |=> flag_q);

  a_r10_zero_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (en_start && rlo_q == 8'h00 && rhi_q == 8'h00 && !(reg_wr && reg_addr != A_CTRL))
      |=> (cnt_q == CW'(17'h10000)));
endmodule

// File: tb/tick_timer_tb_top.sv
`timescale 1ns/1ps
module tick_timer_tb_top;
  localparam int DIV = 2;
  localparam int AW  = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic          ref_tick = 1'b0;
  logic          wdog_busy = 1'b0;
  logic          irq;

  int vectors = 0;
  int misses = 0;
  int cycles = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] rd;
    logic       irq;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  tick_timer #(.DIV(DIV), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ref_tick(ref_tick),
    .wdog_busy(wdog_busy), .irq(irq)
  );

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      vectors++;
      if (reg_rdata !== it.rd || irq !== it.irq) begin
        misses++;
        $display("FAIL %s: rdata=%02h irq=%0b expected rdata=%02h irq=%0b",
                 it.tag, reg_rdata, irq, it.rd, it.irq);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      misses++;
      vectors++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #2;
    reg_wr = 1'b0;
  endtask

  task automatic tick(input int n);
    @(posedge clk); #2;
    ref_tick = 1'b1;
    repeat (n) @(posedge clk);
    #2 ref_tick = 1'b0;
  endtask

  task automatic expect_rd(input logic [AW-1:0] a, input logic [7:0] rd,
                           input logic ir, input string tag);
    exp_t it;
    @(posedge clk); #2;
    reg_addr = a;
    it.rd = rd; it.irq = ir; it.tag = tag;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    expect_rd(0, 8'h00, 1'b0, "R1 ctrl after reset");
    expect_rd(1, 8'h00, 1'b0, "R1 reload low after reset");
    expect_rd(2, 8'h00, 1'b0, "R1 reload high after reset");
    expect_rd(3, 8'h00, 1'b0, "R1 prescale after reset");

    wr(1, 8'h03);
    wr(2, 8'h5A);
    expect_rd(1, 8'h03, 1'b0, "R2 reload low readback");
    expect_rd(2, 8'h5A, 1'b0, "R2 reload high readback");
    wr(2, 8'h00);
    wr(0, 8'h70);
    expect_rd(0, 8'h00, 1'b0, "R2 watchdog bits ignored");

    wdog_busy = 1'b1;
    expect_rd(0, 8'h80, 1'b0, "R2 busy visible at bit 7");
    wr(0, 8'h08);
    expect_rd(0, 8'h80, 1'b0, "R3 enable refused while busy");
    wdog_busy = 1'b0;
    expect_rd(0, 8'h00, 1'b0, "R3 enable still clear");

    tick(1);
    expect_rd(3, 8'h01, 1'b0, "R4 prescale advances");
    wr(3, 8'h01);
    expect_rd(3, 8'h01, 1'b0, "R4 nonzero prescale write ignored");
    wr(3, 8'h00);
    expect_rd(3, 8'h00, 1'b0, "R4 prescale zeroed");
    tick(2);
    expect_rd(3, 8'h00, 1'b0, "R4 prescale wraps after DIV");

    wr(0, 8'h0D);
    tick(5);
    expect_rd(0, 8'h0D, 1'b0, "R5 no flag one tick early");
    tick(1);
    expect_rd(0, 8'h0F, 1'b1, "R5 R9 flag and irq at expiry");

    wr(0, 8'h0D);
    expect_rd(0, 8'h0F, 1'b1, "R8 write of 0 to flag keeps it");
    wr(0, 8'h0F);
    expect_rd(0, 8'h0D, 1'b0, "R8 write of 1 clears flag");

    tick(5);
    expect_rd(0, 8'h0D, 1'b0, "R6 periodic no early flag");
    tick(1);
    expect_rd(0, 8'h0F, 1'b1, "R6 periodic second expiry");

    wr(0, 8'h09);
    expect_rd(0, 8'h0B, 1'b0, "R9 irq low when enable off");

    wr(0, 8'h02);
    expect_rd(0, 8'h00, 1'b0, "R8 disable and clear");
    wr(3, 8'h00);
    wr(0, 8'h0C);
    tick(5);
    expect_rd(0, 8'h0C, 1'b0, "R7 single-shot before expiry");
    tick(1);
    expect_rd(0, 8'h06, 1'b1, "R7 single-shot expiry clears enable");
    wr(0, 8'h06);
    expect_rd(0, 8'h04, 1'b0, "R7 flag cleared after stop");
    tick(20);
    expect_rd(0, 8'h04, 1'b0, "R7 stopped counter stays quiet");

    wr(1, 8'h00);
    wr(3, 8'h00);
    wr(0, 8'h0C);
    tick(65536 * DIV - 1);
    expect_rd(0, 8'h0C, 1'b0, "R10 zero reload not yet expired");
    tick(1);
    expect_rd(0, 8'h06, 1'b1, "R10 zero reload expires at 65536");

    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule